// File: doc/BRIEF.md
# Adaptive-Period Watchdog Timer

This block supervises a processor by watching a strobe line that software toggles while it runs normally. The block counts timebase clock cycles between strobe transitions. If no transition arrives within the allowed window, it raises a one-cycle timeout request and pulls its active-low watchdog status low. Another block turns that request into a system reset pulse.

The window depends on what happened last. After any reset ends, and after every timeout, the long window applies. This gives software time to initialise before it has to service the strobe. Each counted strobe transition re-arms the timer with the normal window. The normal window is short unless the period-select input asks for the long one.

The strobe arrives as a three-level input: a valid flag plus a level. When the valid flag is low, the line is floating or at mid level, and the watchdog is off. While the system reset is active, while the block is in backup mode, or while the strobe is off, the timer is held and re-armed with the long window.

Top module: `wdt_adaptive`

## Requirements
- R1: While rst_ni is low, timeout_o is 0 and wd_status_no is 1.
- R2: A strobe transition counts when it is in either direction and the synchronised valid flag was 1 both before and after it. A counted transition re-arms the timer. With sel_long_i = 0, the next timeout_o pulse comes SHORT_CYC + 3 clock edges after an input change that is launched just after an edge, provided no further transition arrives.
- R3: When sys_rst_i falls, the long window restarts. timeout_o is seen LONG_CYC cycles later unless a transition is counted first.
- R4: timeout_o is high for exactly one cycle. wd_status_no goes low on the next edge and stays low until a counted strobe transition, the low-supply flag, backup mode or a disabled strobe sets it high.
- R5: If the strobe never toggles, timeout_o pulses repeat exactly LONG_CYC cycles apart.
- R6: With sel_long_i = 1, a counted transition re-arms the timer with LONG_CYC instead of SHORT_CYC.
- R7: While strobe_valid_i = 0 (floating or mid level), no timeout occurs and wd_status_no is 1.
- R8: While low_supply_i = 1, wd_status_no is 1 from the next edge on.
- R9: While backup_i = 1, strobe activity is ignored, no timeout occurs and wd_status_no is 1.
- R10: A level change made while strobe_valid_i = 0 is not counted when the strobe becomes valid again. The timer restarts with the long window, so timeout_o is seen LONG_CYC + 2 cycles after the valid flag returns.
- R11: While sys_rst_i = 1, no timeout occurs and the timer is held.
- R12: Strobe transitions while sys_rst_i = 1 are ignored and do not set wd_status_no high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Timebase clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| strobe_valid_i | input | 1 | 1 when the strobe is driven to a valid level, 0 when it is floating or at mid level |
| strobe_level_i | input | 1 | Strobe logic level; used only when strobe_valid_i is 1 |
| sel_long_i | input | 1 | 1 selects the long window as the normal period |
| sys_rst_i | input | 1 | System reset pulse is active |
| low_supply_i | input | 1 | Supply is below its threshold |
| backup_i | input | 1 | Block is running in backup mode |
| timeout_o | output | 1 | One-cycle timeout request |
| wd_status_no | output | 1 | Latched watchdog status, active low |

## Verification
A wrong count state shows up at timeout_o as a pulse that is early or late by a measurable number of cycles. A wrong reload choice is worse: it shifts the pulse by the whole difference between the two windows, so the mistake is visible within one period after the fault. A wrong status latch shows on wd_status_no one edge after the timeout, or one edge after the transition, flag or mode change that should have set it. A per-cycle reference model flags the first cycle in which either output disagrees. Cycle-exact directed measurements pin down each window length.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  function automatic int cnt_bits(input int cycles);
    return (cycles <= 2) ? 1 : $clog2(cycles);
  endfunction
endpackage

// File: rtl/wdt_strobe_sync.sv
module wdt_strobe_sync #(
  parameter int SYNC_N = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic valid_i,
  input  logic level_i,
  output logic drv_o,
  output logic edge_o
);
  logic [SYNC_N-1:0] v_sync, l_sync;
  logic              v_q, l_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      v_sync <= '0;
      l_sync <= '0;
      v_q    <= 1'b0;
      l_q    <= 1'b0;
    end else begin
      v_sync <= {v_sync[SYNC_N-2:0], valid_i};
      l_sync <= {l_sync[SYNC_N-2:0], level_i};
      v_q    <= v_sync[SYNC_N-1];
      l_q    <= l_sync[SYNC_N-1];
    end
  end

  assign drv_o  = v_sync[SYNC_N-1];
  // only valid-to-valid level changes count
  assign edge_o = v_sync[SYNC_N-1] & v_q & (l_sync[SYNC_N-1] ^ l_q);

  assert_edge_needs_valid_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    edge_o |-> (drv_o && $past(drv_o)));
endmodule

// File: rtl/wdt_period_sel.sv
module wdt_period_sel #(
  parameter int SHORT_CYC = 1024,
  parameter int LONG_CYC  = 4096,
  parameter int CNT_W     = 12
) (
  input  logic             sel_long_i,
  input  logic             hit_i,
  output logic [CNT_W-1:0] reload_o
);
  localparam logic [CNT_W-1:0] SHORT_M1 = CNT_W'(SHORT_CYC - 1);
  localparam logic [CNT_W-1:0] LONG_M1  = CNT_W'(LONG_CYC - 1);

  // a counted edge arms the normal window; everything else arms the long one
  always_comb begin
    if (hit_i && !sel_long_i) reload_o = SHORT_M1;
    else                      reload_o = LONG_M1;
  end
endmodule

// File: rtl/wdt_down_cnt.sv
module wdt_down_cnt #(
  parameter int LONG_CYC = 4096,
  parameter int CNT_W    = 12
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             hit_i,
  input  logic [CNT_W-1:0] reload_i,
  output logic             expire_o
);
  localparam logic [CNT_W-1:0] LONG_M1 = CNT_W'(LONG_CYC - 1);

  logic [CNT_W-1:0] cnt_q;

  assign expire_o = run_i & ~hit_i & (cnt_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 cnt_q <= LONG_M1;
    else if (!run_i)             cnt_q <= LONG_M1;
    else if (hit_i || expire_o)  cnt_q <= reload_i;
    else                         cnt_q <= cnt_q - 1'b1;
  end

  assert_pulse_one_cycle_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    expire_o |=> !expire_o);
  assert_held_no_expire_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> !expire_o);
endmodule

// File: rtl/wdt_adaptive.sv
module wdt_adaptive #(
  parameter int SHORT_CYC = 1024,
  parameter int LONG_CYC  = 4096
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic strobe_valid_i,
  input  logic strobe_level_i,
  input  logic sel_long_i,
  input  logic sys_rst_i,
  input  logic low_supply_i,
  input  logic backup_i,
  output logic timeout_o,
  output logic wd_status_no
);
  localparam int CNT_W = wdt_pkg::cnt_bits(LONG_CYC);

  logic             drv, strobe_edge, run, hit, expire;
  logic [CNT_W-1:0] reload;
  logic             status_q;

  wdt_strobe_sync #(.SYNC_N(2)) u_sync (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .valid_i (strobe_valid_i),
    .level_i (strobe_level_i),
    .drv_o   (drv),
    .edge_o  (strobe_edge)
  );

  assign run = drv & ~backup_i & ~sys_rst_i;
  assign hit = strobe_edge & run;

  wdt_period_sel #(.SHORT_CYC(SHORT_CYC), .LONG_CYC(LONG_CYC), .CNT_W(CNT_W)) u_sel (
    .sel_long_i (sel_long_i),
    .hit_i      (hit),
    .reload_o   (reload)
  );

  wdt_down_cnt #(.LONG_CYC(LONG_CYC), .CNT_W(CNT_W)) u_cnt (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .run_i    (run),
    .hit_i    (hit),
    .reload_i (reload),
    .expire_o (expire)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                             status_q <= 1'b1;
    else if (low_supply_i || !drv || backup_i) status_q <= 1'b1;
    else if (hit)                            status_q <= 1'b1;
    else if (expire)                         status_q <= 1'b0;
  end

  assign timeout_o    = expire;
  assign wd_status_no = status_q;

  assert_low_supply_high_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    low_supply_i |=> wd_status_no);
  assert_timeout_drops_status_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (timeout_o && !low_supply_i) |=> !wd_status_no);
  assert_status_rise_cause_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(wd_status_no) |-> $past(low_supply_i || backup_i || hit || !drv));
  assert_backup_quiet_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    backup_i |-> !timeout_o);
  assert_sysrst_quiet_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sys_rst_i |-> !timeout_o);
endmodule

// File: tb/wdt_adaptive_test.sv
module wdt_adaptive_test;
  localparam int SHORT = 16;
  localparam int LONG  = 64;

  logic clk = 1'b0, rst_n = 1'b0;
  logic sv = 1'b1, sl = 1'b0, sel = 1'b0, srst = 1'b0, lows = 1'b0, bk = 1'b0;
  logic to, st_n;
  int   nchecks = 0, nerr = 0;
  bit   chk_en = 1'b0;
  string tag = "R1";

  always #4 clk = ~clk;

  wdt_adaptive #(.SHORT_CYC(SHORT), .LONG_CYC(LONG)) uut (
    .clk_i(clk), .rst_ni(rst_n), .strobe_valid_i(sv), .strobe_level_i(sl),
    .sel_long_i(sel), .sys_rst_i(srst), .low_supply_i(lows), .backup_i(bk),
    .timeout_o(to), .wd_status_no(st_n)
  );

  // reference model of the requirements, cycle level
  bit s1v, s1l, s2v, s2l, qv, ql, m_stat;
  int m_cnt;

  function automatic bit f_run();
    return s2v && !bk && !srst;
  endfunction
  function automatic bit f_hit();
    return s2v && qv && (s2l != ql) && f_run();
  endfunction
  function automatic bit f_exp();
    return f_run() && (m_cnt == 0) && !f_hit();
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1v = 0; s1l = 0; s2v = 0; s2l = 0; qv = 0; ql = 0;
      m_cnt = LONG - 1; m_stat = 1;
    end else begin
      automatic bit r = f_run();
      automatic bit h = f_hit();
      automatic bit e = f_exp();
      if (lows || !s2v || bk) m_stat = 1;
      else if (h)             m_stat = 1;
      else if (e)             m_stat = 0;
      if (!r)          m_cnt = LONG - 1;
      else if (h)      m_cnt = (sel ? LONG : SHORT) - 1;
      else if (e)      m_cnt = LONG - 1;
      else             m_cnt = m_cnt - 1;
      qv = s2v; ql = s2l; s2v = s1v; s2l = s1l; s1v = sv; s1l = sl;
    end
  end

  task automatic chk(input string t, input int act, input int exp);
    nchecks++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s: actual %0d expected %0d at %0t", t, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && chk_en) begin
      chk(tag, to, f_exp());
      chk(tag, st_n, m_stat);
    end
  end

  task automatic drive_step();
    @(posedge clk); #1;
  endtask

  task automatic meas(output int n);
    n = 0;
    while (n < 5 * LONG) begin
      @(negedge clk);
      n++;
      if (to) break;
    end
  endtask

  task automatic count_to(input int cycles, input bit toggle, output int hits);
    hits = 0;
    for (int i = 0; i < cycles; i++) begin
      drive_step();
      if (toggle && (i % 5 == 0)) sl = ~sl;
      @(negedge clk);
      if (to) hits++;
    end
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", nchecks, nerr);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nerr++;
    $display("FAIL watchdog: run did not complete");
    summary();
    $finish;
  end

  initial begin
    int n, h;
    void'($urandom(32'h5eed_1234));
    // R1 reset state
    repeat (3) @(negedge clk);
    chk("R1", to, 0);
    chk("R1", st_n, 1);
    drive_step();
    rst_n = 1'b1;
    chk_en = 1'b1;

    // R5 idle strobe: pulses LONG apart; R4 pulse width and status
    tag = "R5";
    meas(n);
    meas(n);
    chk("R5", n, LONG);
    @(negedge clk);
    chk("R4", to, 0);
    chk("R4", st_n, 0);
    repeat (5) @(negedge clk);
    chk("R4", st_n, 0);

    // R12 edges under system reset ignored; R11 hold
    tag = "R12";
    drive_step(); srst = 1'b1;
    repeat (3) begin repeat (4) drive_step(); sl = ~sl; end
    repeat (8) @(negedge clk);
    chk("R12", st_n, 0);
    tag = "R11";
    count_to(LONG + 10, 1'b0, h);
    chk("R11", h, 0);

    // R3 long window after system reset release
    tag = "R3";
    drive_step(); srst = 1'b0;
    meas(n);
    chk("R3", n, LONG);

    // R2 both polarities, short window
    tag = "R2";
    drive_step(); sl = ~sl;
    meas(n);
    chk("R2", n, SHORT + 3);
    drive_step(); sl = ~sl;
    meas(n);
    chk("R2", n, SHORT + 3);

    // R6 long normal period
    tag = "R6";
    drive_step(); sel = 1'b1;
    drive_step(); sl = ~sl;
    meas(n);
    chk("R6", n, LONG + 3);
    drive_step(); sel = 1'b0;

    // R10 level change through mid not counted
    tag = "R10";
    drive_step(); sl = ~sl;
    repeat (3) drive_step();
    sv = 1'b0;
    drive_step(); sl = ~sl;
    repeat (5) drive_step();
    sv = 1'b1;
    meas(n);
    chk("R10", n, LONG + 2);

    // R8 low supply forces status high
    tag = "R8";
    @(negedge clk);
    chk("R8", st_n, 0);
    drive_step(); lows = 1'b1;
    @(negedge clk); @(negedge clk);
    chk("R8", st_n, 1);
    drive_step(); lows = 1'b0;

    // R9 backup mode ignores strobe
    tag = "R9";
    drive_step(); bk = 1'b1;
    count_to(LONG + 20, 1'b1, h);
    chk("R9", h, 0);
    chk("R9", st_n, 1);
    drive_step(); bk = 1'b0;

    // R7 floating strobe disables
    tag = "R7";
    drive_step(); sv = 1'b0;
    count_to(2 * LONG, 1'b1, h);
    chk("R7", h, 0);
    chk("R7", st_n, 1);
    drive_step(); sv = 1'b1;

    // constrained random, model compared every cycle
    tag = "R2";
    for (int i = 0; i < 4000; i++) begin
      drive_step();
      if ((i < 2000) ? ($urandom % 6 == 0) : ($urandom % 40 == 0)) sl = ~sl;
      sv   = ($urandom % 60) != 0;
      srst = ($urandom % 100) < 3;
      bk   = ($urandom % 200) == 0;
      lows = ($urandom % 150) == 0;
      if ($urandom % 500 == 0) sel = ~sel;
    end
    repeat (4) @(negedge clk);
    summary();
    $finish;
  end
endmodule